// File: doc/BRIEF.md
# Time-Division Duplex Slot Scheduler

This block keeps a free-running native clock for one end of a two-party time-division duplex radio link and cuts time into equal slots. It reports the running clock, the slot number, a strobe at the start of each slot and a strobe at each half-slot point. It also opens a transmit window or a receive window for every slot. Which slots belong to the local end depends on its role. The master owns the even slots and the slave owns the odd ones. The role is latched while reset is held.

The link layer above asks for a packet of 1, 3 or 5 slots. The block holds the request until the next slot boundary that leads into a slot the role may start in. It then keeps the transmit window open for the whole packet. The slot right after the packet is always given to the peer, so that the peer can acknowledge it. Any other length is refused with a one-cycle error pulse. A request that arrives while a packet is still waiting, being sent, or awaiting its response is dropped. At 312.5 µs per clock tick, one slot lasts 625 µs. The prescaler depth sets how many system clock cycles make one tick.

Top module: `tdd_slot_sched`

## Requirements
- R1: After reset the native clock reads 0. It advances by exactly one every TICK_DIV clock cycles and wraps modulo 2^CLK_W (default 28 bits). A tick therefore marks half a slot.
- R2: The slot index equals the native clock without its lowest bit. slot_start pulses for one cycle in the cycle the clock changes to an even value. half_start pulses for one cycle when it changes to an odd value.
- R3: role_master is sampled only while rst_n is low. A value of 1 makes the local end the master, which owns slots with an even index. A value of 0 makes it the slave, which owns slots with an odd index. Changes to role_master after reset have no effect.
- R4: A legal request is taken in the cycle tx_req is high. tx_en then rises together with slot_start at the first later boundary whose new slot is owned by the local role. A request taken in a cycle that itself ends a slot waits for the following boundary.
- R5: tx_slots is a plain binary slot count. For a count of 1, 3 or 5, tx_en stays high for exactly that many whole slots.
- R6: In the slot right after the last transmit slot, tx_en is low and rx_en is high, so the peer can answer.
- R7: A request with tx_slots of 0, 2, 4, 6 or 7 raises len_err for exactly one cycle, the cycle after the request. The request is otherwise dropped, and no transmit window follows.
- R8: A request made while a previous packet is waiting, transmitting or in its response slot is ignored. The earlier packet's window does not change.
- R9: tx_en and rx_en are never high together. Outside a local packet, rx_en is high in every slot owned by the peer and low in every idle slot owned by the local end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; role is latched while low |
| role_master | input | 1 | 1 = master (even slots), 0 = slave (odd slots) |
| tx_req | input | 1 | One-cycle request to send a packet |
| tx_slots | input | 3 | Packet length in slots, binary |
| nclk | output | CLK_W | Native clock, one count per half slot |
| slot_idx | output | CLK_W-1 | Current slot number |
| slot_start | output | 1 | One-cycle strobe at each slot start |
| half_start | output | 1 | One-cycle strobe at each slot midpoint |
| tx_en | output | 1 | Local transmit window |
| rx_en | output | 1 | Local receive window |
| len_err | output | 1 | One-cycle pulse for an illegal packet length |

## Verification
The hardest event to reach from the ports is the wrap of the native clock: at full width it would take 2^28 ticks. The bench therefore overrides the counter width to 8 bits. The clock then rolls over every 1024 cycles while packets of random length keep running across the wrap, and slot parity and strobes are checked every cycle through the rollover. The second delicate point is where a request lands within a slot. Each request is placed at a random offset away from the closing cycle of its slot, so the start slot can be predicted from the slot number alone.

// File: rtl/tdd_pkg.sv
package tdd_pkg;

  localparam int LEN_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TX   = 2'd2,
    ST_RESP = 2'd3
  } sched_st_e;

  // legal packet lengths are the odd counts 1, 3 and 5
  function automatic logic slots_legal(input logic [LEN_W-1:0] n);
    return (n == 3'd1) || (n == 3'd3) || (n == 3'd5);
  endfunction

  // slot parity 0 = even slot; master owns even, slave owns odd
  function automatic logic slot_is_own(input logic is_master, input logic par);
    return is_master ? !par : par;
  endfunction

endpackage

// File: rtl/tdd_tick_gen.sv
module tdd_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pres;

  assign tick = (pres == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    pres <= '0;
    else if (tick) pres <= '0;
    else           pres <= pres + PW'(1);
  end

  AST_PRES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pres <= PRE_LAST);  // R1
endmodule

// File: rtl/tdd_native_clk.sv
module tdd_native_clk #(
  parameter int CLK_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CLK_W-1:0] nclk,
  output logic             bnd,
  output logic             slot_start,
  output logic             half_start
);
  // bnd: this tick moves the clock onto an even value, i.e. a new slot
  assign bnd = tick && nclk[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nclk       <= '0;
      slot_start <= 1'b0;
      half_start <= 1'b0;
    end else begin
      if (tick) nclk <= nclk + CLK_W'(1);
      slot_start <= bnd;
      half_start <= tick && !nclk[0];
    end
  end

  AST_NCLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (nclk == $past(nclk) + CLK_W'(1)));  // R1
  AST_NCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(nclk));  // R1
  AST_SLOT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> !nclk[0]);  // R2
  AST_HALF_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    half_start |-> nclk[0]);  // R2
endmodule

// File: rtl/tdd_slot_ctrl.sv
module tdd_slot_ctrl
  import tdd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_master,
  input  logic             bnd,
  input  logic             slot_par,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_slots,
  output logic             tx_en,
  output logic             rx_en,
  output logic             len_err
);
  sched_st_e        st;
  logic             role_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] rem;
  logic             own_next;
  logic             own_now;
  logic             req_ok;

  assign own_next = slot_is_own(role_q, !slot_par);
  assign own_now  = slot_is_own(role_q, slot_par);
  assign req_ok   = tx_req && slots_legal(tx_slots);

  always_ff @(posedge clk) begin
    if (!rst_n) role_q <= role_master;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      len_q   <= '0;
      rem     <= '0;
      len_err <= 1'b0;
    end else begin
      len_err <= tx_req && !slots_legal(tx_slots);
      unique case (st)
        ST_IDLE: if (req_ok) begin
          len_q <= tx_slots;
          st    <= ST_WAIT;
        end
        ST_WAIT: if (bnd && own_next) begin
          rem <= len_q - LEN_W'(1);
          st  <= ST_TX;
        end
        ST_TX: if (bnd) begin
          if (rem == '0) st <= ST_RESP;
          else           rem <= rem - LEN_W'(1);
        end
        ST_RESP: if (bnd) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tx_en = (st == ST_TX);
  assign rx_en = (st == ST_RESP) || ((st != ST_TX) && !own_now);

  AST_TX_OWN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> slot_is_own(role_q, slot_par));  // R3
  AST_ROLE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(role_q));  // R3
  AST_BAD_LEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && tx_req && !slots_legal(tx_slots)) |=> (st == ST_IDLE));  // R7
  AST_TX_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && bnd && rem != '0) |=> tx_en);  // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && rx_en));  // R9
endmodule

// File: rtl/tdd_slot_sched.sv
module tdd_slot_sched
  import tdd_pkg::*;
#(
  parameter int CLK_W    = 28,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             role_master,
  input  logic             tx_req,
  input  logic [LEN_W-1:0] tx_slots,
  output logic [CLK_W-1:0] nclk,
  output logic [CLK_W-2:0] slot_idx,
  output logic             slot_start,
  output logic             half_start,
  output logic             tx_en,
  output logic             rx_en,
  output logic             len_err
);
  logic tick;
  logic bnd;

  tdd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  tdd_native_clk #(.CLK_W(CLK_W)) u_nclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .nclk      (nclk),
    .bnd       (bnd),
    .slot_start(slot_start),
    .half_start(half_start)
  );

  assign slot_idx = nclk[CLK_W-1:1];

  tdd_slot_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_master(role_master),
    .bnd        (bnd),
    .slot_par   (nclk[1]),
    .tx_req     (tx_req),
    .tx_slots   (tx_slots),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .len_err    (len_err)
  );

  AST_TX_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> slot_start);  // R4
  AST_RESP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (rx_en && slot_start));  // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slot_start, half_start}));  // R2
endmodule

// File: tb/tdd_slot_sched_bench.sv
`timescale 1ns/1ps
module tdd_slot_sched_bench;
  localparam int W   = 8;
  localparam int DIV = 4;
  localparam int SL  = 2 * DIV;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         role_master = 1'b1;
  logic         tx_req = 1'b0;
  logic [2:0]   tx_slots = 3'd0;
  logic [W-1:0] nclk;
  logic [W-2:0] slot_idx;
  logic         slot_start, half_start, tx_en, rx_en, len_err;

  int  cyc = 0;
  int  checks = 0;
  int  errs = 0;
  bit  mon_on = 1'b0;
  bit  bench_master = 1'b1;
  int  seed_val;

  tdd_slot_sched #(.CLK_W(W), .TICK_DIV(DIV)) u_tdd_slot_sched (
    .clk(clk), .rst_n(rst_n), .role_master(role_master),
    .tx_req(tx_req), .tx_slots(tx_slots), .nclk(nclk), .slot_idx(slot_idx),
    .slot_start(slot_start), .half_start(half_start),
    .tx_en(tx_en), .rx_en(rx_en), .len_err(len_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit own(input int t);
    return bench_master ? (t % 2 == 0) : (t % 2 == 1);
  endfunction

  function automatic bit legal(input int n);
    return (n == 1) || (n == 3) || (n == 5);
  endfunction

  // per-cycle clock, strobe and exclusivity monitor
  always @(negedge clk) begin
    if (mon_on) begin
      chk(int'(nclk) == (cyc / DIV) % (1 << W), "R1", "nclk", int'(nclk), (cyc / DIV) % (1 << W));
      chk(int'(slot_idx) == ((cyc / DIV) % (1 << W)) / 2, "R2", "slot_idx",
          int'(slot_idx), ((cyc / DIV) % (1 << W)) / 2);
      chk(slot_start == (cyc > 0 && cyc % SL == 0), "R2", "slot_start",
          int'(slot_start), int'(cyc > 0 && cyc % SL == 0));
      chk(half_start == (cyc % SL == DIV), "R2", "half_start",
          int'(half_start), int'(cyc % SL == DIV));
      chk(!(tx_en && rx_en), "R9", "tx_en&rx_en", int'(tx_en && rx_en), 0);
    end
  end

  task automatic mid_slot(input int t);
    do @(negedge clk); while (cyc != t * SL + DIV);
  endtask

  task automatic do_reset(input bit master);
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    role_master = master;
    bench_master = master;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk(nclk == '0, "R1", "reset nclk", int'(nclk), 0);
    chk(tx_en == 1'b0, "R9", "reset tx_en", int'(tx_en), 0);
    chk(len_err == 1'b0, "R7", "reset len_err", int'(len_err), 0);
    chk(rx_en == !master, "R9", "reset rx_en", int'(rx_en), int'(!master));
    @(negedge clk);
    mon_on = 1'b1;
  endtask

  // issue one request and check the slot-by-slot windows that follow
  task automatic send(input int len, input bit extra);
    int off, c, s, start;
    bit etx, erx;
    off = 1 + int'($urandom % (SL - 2));
    do @(negedge clk); while (cyc % SL != off);
    c = cyc;
    tx_req = 1'b1;
    tx_slots = 3'(len);
    @(negedge clk);
    tx_req = 1'b0;
    s = c / SL;
    chk(len_err == !legal(len), "R7", "len_err after request", int'(len_err), int'(!legal(len)));
    @(negedge clk);
    chk(len_err == 1'b0, "R7", "len_err one cycle", int'(len_err), 0);
    if (!legal(len)) begin
      for (int t = s + 1; t <= s + 3; t++) begin
        mid_slot(t);
        chk(tx_en == 1'b0, "R7", "tx_en after bad length", int'(tx_en), 0);
        chk(rx_en == !own(t), "R9", "rx_en idle", int'(rx_en), int'(!own(t)));
      end
    end else begin
      start = own(s + 1) ? s + 1 : s + 2;
      for (int t = s + 1; t <= start + len + 1; t++) begin
        mid_slot(t);
        etx = (t >= start) && (t < start + len);
        erx = (t == start + len) || (!etx && !own(t));
        if (t < start)
          chk(tx_en == 1'b0, "R4", "tx_en before start", int'(tx_en), 0);
        else if (t < start + len)
          chk(tx_en == 1'b1, "R5", "tx_en in packet", int'(tx_en), 1);
        else if (t == start + len)
          chk(tx_en == 1'b0 && rx_en == 1'b1, "R6", "response slot tx/rx",
              int'({tx_en, rx_en}), 1);
        else
          chk(tx_en == 1'b0, extra ? "R8" : "R5", "tx_en after response", int'(tx_en), 0);
        chk(rx_en == erx, "R9", "rx_en", int'(rx_en), int'(erx));
        if (extra && t == start) begin
          tx_req = 1'b1;
          tx_slots = 3'd3;
          @(negedge clk);
          tx_req = 1'b0;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    seed_val = int'($urandom(32'h5eed));
    do_reset(1'b1);
    // directed: each legal length as master
    send(1, 1'b0);
    send(3, 1'b0);
    send(5, 1'b0);
    // R8: extra request during a packet is ignored
    send(3, 1'b1);
    send(5, 1'b1);
    // R7: every illegal length
    send(0, 1'b0);
    send(2, 1'b0);
    send(4, 1'b0);
    send(6, 1'b0);
    send(7, 1'b0);
    // R3: role input changed after reset has no effect
    role_master = 1'b0;
    send(1, 1'b0);
    send(3, 1'b0);
    role_master = 1'b1;
    // R1: explicit wrap point
    do @(negedge clk); while (cyc % (DIV << W) != 0 || cyc == 0);
    chk(nclk == '0 && slot_start, "R1", "wrap to zero", int'(nclk), 0);
    // random mix, crossing several wraps
    for (int i = 0; i < 40; i++) send(int'($urandom % 8), ($urandom % 4) == 0);
    // slave role
    do_reset(1'b0);
    send(1, 1'b0);
    send(5, 1'b0);
    send(3, 1'b1);
    role_master = 1'b1;
    send(3, 1'b0);
    for (int i = 0; i < 40; i++) send(int'($urandom % 8), ($urandom % 4) == 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule